// File: doc/BRIEF.md
# Temperature-Banded Calibration Selector

This block keeps a small table of calibration coefficient pairs for an ADC's measurement channel. Each pair is a zero-scale and a full-scale coefficient, and each is tagged with the raw code that the temperature channel produced when that pair was calibrated. By default there are seven entries, each covering a 10-degree band centred on its calibration temperature. Drift inside a band is not corrected. The measurement channel is never recalibrated in service. Only stored pairs are loaded into it.

In learn mode (`learn_i` high) the host writes entries by index. In run mode it hands over temperature-channel results, which it may sample far less often than the measurement channel. Entries are written in ascending order of temperature code. For each result the block picks the entry whose code is nearest, with each boundary at the midpoint between neighbouring entries. A programmable hysteresis keeps the band from chattering when the result sits near a boundary. A one-cycle load request, carrying the pair and the band index, is issued only when the chosen band differs from the band in use.

Top module: `tbc_select`

## Requirements
- R1: While `rst_ni` is low and after its release, `load_o` and `band_valid_o` are 0 and `band_o` is 0.
- R2: When `learn_i` and `wr_valid_i` are both high at a clock edge, the entry at `wr_idx_i` takes `wr_zs_i`, `wr_fs_i` and `wr_temp_i`. A later load of that band carries the written pair.
- R3: A write presented while `learn_i` is low leaves the table unchanged, including when it falls in the same cycle as a temperature result.
- R4: A temperature result presented while `learn_i` is high produces no load and does not change `band_o`.
- R5: The raw band is the number of boundaries k (0 to N-2) for which the code is greater than or equal to floor((t[k]+t[k+1])/2), where t are the stored codes. A code equal to a midpoint belongs to the upper band.
- R6: The first run-mode result after reset, or after learn mode, always loads its raw band, even if that band equals the previous `band_o`.
- R7: A load appears in the cycle after the accepted `temp_valid_i`. It lasts one cycle, with `load_zs_o`, `load_fs_o` and `load_band_o` equal to the selected entry. `band_o` takes the new band on the same edge.
- R8: No load is issued when the selected band equals the current band.
- R9: A move to a higher band requires the code to be at least the boundary above the current band plus `hyst_i`.
- R10: A move to a lower band requires the code plus `hyst_i` to be strictly below the boundary beneath the current band.
- R11: Once the adjacent boundary is cleared, the block moves directly to the raw band, even when that band is several bands away.
- R12: The clock edge after `learn_i` is seen high, `band_valid_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| learn_i | input | 1 | 1 = learn mode (table writes), 0 = run mode |
| wr_valid_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_zs_i | input | COEF_W | Zero-scale coefficient to store |
| wr_fs_i | input | COEF_W | Full-scale coefficient to store |
| wr_temp_i | input | TEMP_W | Temperature code taken at calibration |
| hyst_i | input | HYST_W | Hysteresis in codes |
| temp_valid_i | input | 1 | New temperature-channel result |
| temp_code_i | input | TEMP_W | Temperature-channel code (unsigned) |
| load_o | output | 1 | One-cycle coefficient load request |
| load_band_o | output | IDX_W | Band index of the load |
| load_zs_o | output | COEF_W | Zero-scale coefficient to load |
| load_fs_o | output | COEF_W | Full-scale coefficient to load |
| band_o | output | IDX_W | Band currently in use |
| band_valid_o | output | 1 | A band has been selected since learn mode or reset |

## Verification
Two functions can meet in one cycle: a table write and a temperature result, and a temperature result and a mode change. The bench presents a run-mode write to an entry in the same cycle as a result that selects that entry. It then checks that the load carries the old pair. It also presents a result together with a write during learn mode, and expects no load and an updated table. Leaving learn mode is judged by the first result after it: that result must load even though its band matches the band held before.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int unsigned DEF_BANDS  = 7;
  localparam int unsigned DEF_COEF_W = 24;
  localparam int unsigned DEF_TEMP_W = 24;
  localparam int unsigned DEF_HYST_W = 8;
endpackage

// File: rtl/tbc_table.sv
module tbc_table #(
  parameter int unsigned N      = tbc_pkg::DEF_BANDS,
  parameter int unsigned COEF_W = tbc_pkg::DEF_COEF_W,
  parameter int unsigned TEMP_W = tbc_pkg::DEF_TEMP_W,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [COEF_W-1:0] zs_i,
  input  logic [COEF_W-1:0] fs_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [COEF_W-1:0] zs_o   [N],
  output logic [COEF_W-1:0] fs_o   [N],
  output logic [TEMP_W-1:0] temp_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        zs_o[g]   <= '0;
        fs_o[g]   <= '0;
        temp_o[g] <= '0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        zs_o[g]   <= zs_i;
        fs_o[g]   <= fs_i;
        temp_o[g] <= temp_i;
      end
    end
  end
endmodule

// File: rtl/tbc_band_find.sv
module tbc_band_find #(
  parameter int unsigned N      = tbc_pkg::DEF_BANDS,
  parameter int unsigned TEMP_W = tbc_pkg::DEF_TEMP_W,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic [TEMP_W-1:0] temp_i [N],
  input  logic [TEMP_W-1:0] code_i,
  output logic [TEMP_W-1:0] mid_o  [N-1],
  output logic [IDX_W-1:0]  raw_o
);
  for (genvar k = 0; k < N - 1; k++) begin : g_mid
    logic [TEMP_W:0] sum;
    assign sum      = {1'b0, temp_i[k]} + {1'b0, temp_i[k+1]};
    assign mid_o[k] = sum[TEMP_W:1];
  end

  // table is ascending, so the count of boundaries passed is the nearest entry
  always_comb begin
    raw_o = '0;
    for (int k = 0; k < N - 1; k++) begin
      if (code_i >= mid_o[k]) raw_o = raw_o + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tbc_band_pick.sv
module tbc_band_pick #(
  parameter int unsigned N      = tbc_pkg::DEF_BANDS,
  parameter int unsigned TEMP_W = tbc_pkg::DEF_TEMP_W,
  parameter int unsigned HYST_W = tbc_pkg::DEF_HYST_W,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic [TEMP_W-1:0] mid_i [N-1],
  input  logic [TEMP_W-1:0] code_i,
  input  logic [HYST_W-1:0] hyst_i,
  input  logic [IDX_W-1:0]  raw_i,
  input  logic [IDX_W-1:0]  cur_i,
  input  logic              valid_i,
  output logic              take_o
);
  localparam int unsigned EXT_W = TEMP_W + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] up_idx, dn_idx;
  logic [EXT_W-1:0] code_x, hyst_x, mid_up, mid_dn;
  logic             up_ok, dn_ok;

  assign up_idx = (cur_i < LAST) ? cur_i : '0;
  assign dn_idx = (cur_i != '0) ? cur_i - IDX_W'(1) : '0;
  assign code_x = {1'b0, code_i};
  assign hyst_x = EXT_W'(hyst_i);
  assign mid_up = {1'b0, mid_i[up_idx]};
  assign mid_dn = {1'b0, mid_i[dn_idx]};

  always_comb begin
    up_ok = 1'b0;
    dn_ok = 1'b0;
    if (raw_i > cur_i) up_ok = code_x >= (mid_up + hyst_x);
    if (raw_i < cur_i) dn_ok = (code_x + hyst_x) < mid_dn;
    take_o = !valid_i || up_ok || dn_ok;
  end
endmodule

// File: rtl/tbc_select.sv
module tbc_select #(
  parameter int unsigned N      = tbc_pkg::DEF_BANDS,
  parameter int unsigned COEF_W = tbc_pkg::DEF_COEF_W,
  parameter int unsigned TEMP_W = tbc_pkg::DEF_TEMP_W,
  parameter int unsigned HYST_W = tbc_pkg::DEF_HYST_W,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              learn_i,
  input  logic              wr_valid_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [COEF_W-1:0] wr_zs_i,
  input  logic [COEF_W-1:0] wr_fs_i,
  input  logic [TEMP_W-1:0] wr_temp_i,
  input  logic [HYST_W-1:0] hyst_i,
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  load_band_o,
  output logic [COEF_W-1:0] load_zs_o,
  output logic [COEF_W-1:0] load_fs_o,
  output logic [IDX_W-1:0]  band_o,
  output logic              band_valid_o
);
  logic [COEF_W-1:0] zs_tab   [N];
  logic [COEF_W-1:0] fs_tab   [N];
  logic [TEMP_W-1:0] temp_tab [N];
  logic [TEMP_W-1:0] mid      [N-1];
  logic [IDX_W-1:0]  raw;
  logic              take;

  tbc_table #(.N(N), .COEF_W(COEF_W), .TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (learn_i & wr_valid_i),
    .idx_i  (wr_idx_i),
    .zs_i   (wr_zs_i),
    .fs_i   (wr_fs_i),
    .temp_i (wr_temp_i),
    .zs_o   (zs_tab),
    .fs_o   (fs_tab),
    .temp_o (temp_tab)
  );

  tbc_band_find #(.N(N), .TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_find (
    .temp_i (temp_tab),
    .code_i (temp_code_i),
    .mid_o  (mid),
    .raw_o  (raw)
  );

  tbc_band_pick #(.N(N), .TEMP_W(TEMP_W), .HYST_W(HYST_W), .IDX_W(IDX_W)) u_pick (
    .mid_i   (mid),
    .code_i  (temp_code_i),
    .hyst_i  (hyst_i),
    .raw_i   (raw),
    .cur_i   (band_o),
    .valid_i (band_valid_o),
    .take_o  (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o       <= 1'b0;
      load_band_o  <= '0;
      load_zs_o    <= '0;
      load_fs_o    <= '0;
      band_o       <= '0;
      band_valid_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (learn_i) begin
        band_valid_o <= 1'b0;
      end else if (temp_valid_i && take) begin
        load_o       <= 1'b1;
        load_band_o  <= raw;
        load_zs_o    <= zs_tab[raw];
        load_fs_o    <= fs_tab[raw];
        band_o       <= raw;
        band_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbc_select_chk.sv
module tbc_select_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             learn_i,
  input logic             temp_valid_i,
  input logic             load_o,
  input logic [IDX_W-1:0] load_band_o,
  input logic [IDX_W-1:0] band_o,
  input logic             band_valid_o
);
  // R4: no load follows a learn-mode cycle
  a_r4_no_load_in_learn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_i |=> !load_o);

  // R12: learn mode drops the selection
  a_r12_learn_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_i |=> !band_valid_o);

  // R7: a load is caused by a run-mode result one cycle earlier
  a_r7_load_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> ($past(temp_valid_i) && !$past(learn_i)));

  // R7: reported band and load band agree
  a_r7_band_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (band_o == load_band_o) && band_valid_o);

  // R8: a load means a new band or a fresh selection
  a_r8_reload_only_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!$past(band_valid_o) || band_o != $past(band_o)));

  // R8: band stays put without a load
  a_r8_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_o && band_valid_o) |-> $stable(band_o));
endmodule

bind tbc_select tbc_select_chk #(.IDX_W(IDX_W)) u_tbc_select_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .learn_i      (learn_i),
  .temp_valid_i (temp_valid_i),
  .load_o       (load_o),
  .load_band_o  (load_band_o),
  .band_o       (band_o),
  .band_valid_o (band_valid_o)
);

// File: tb/tbc_select_bench.sv
module tbc_select_bench;
  localparam int N = 7;
  localparam int CW = 24;
  localparam int TW = 24;
  localparam int HW = 8;
  localparam int IW = 3;
  localparam int NV = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          learn_i = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [CW-1:0] wr_zs_i = '0;
  logic [CW-1:0] wr_fs_i = '0;
  logic [TW-1:0] wr_temp_i = '0;
  logic [HW-1:0] hyst_i = '0;
  logic          temp_valid_i = 1'b0;
  logic [TW-1:0] temp_code_i = '0;
  logic          load_o;
  logic [IW-1:0] load_band_o;
  logic [CW-1:0] load_zs_o;
  logic [CW-1:0] load_fs_o;
  logic [IW-1:0] band_o;
  logic          band_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tbc_select u_tbc_select (.*);

  // {code, hyst, exp_load, exp_band}; table codes 1000..7000, midpoints 1500..6500
  localparam logic [35:0] VEC [NV] = '{
    {24'd100,  8'd50, 1'b1, 3'd0},  // R6 first result
    {24'd1540, 8'd50, 1'b0, 3'd0},  // R9 below mid+hyst
    {24'd1550, 8'd50, 1'b1, 3'd1},  // R9 at mid+hyst
    {24'd1460, 8'd50, 1'b0, 3'd1},  // R10 not cleared
    {24'd1449, 8'd50, 1'b1, 3'd0},  // R10 cleared
    {24'd6999, 8'd50, 1'b1, 3'd6},  // R11 multi-band jump
    {24'd6500, 8'd50, 1'b0, 3'd6},  // R8 same band
    {24'd6460, 8'd50, 1'b0, 3'd6},  // R10 held by hysteresis
    {24'd3000, 8'd50, 1'b1, 3'd2},  // R11 downward jump
    {24'd3500, 8'd0,  1'b1, 3'd3},  // R5 midpoint goes up
    {24'd3499, 8'd0,  1'b1, 3'd2}   // R5 just below midpoint
  };

  function automatic logic [CW-1:0] zs_of(int b); return 24'h100000 + 24'(b * 'h111); endfunction
  function automatic logic [CW-1:0] fs_of(int b); return 24'h800000 + 24'(b * 'h222); endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit wr, input int idx, input logic [CW-1:0] zs, input logic [CW-1:0] fs,
                       input logic [TW-1:0] tc, input bit tv, input logic [TW-1:0] code,
                       input logic [HW-1:0] hy);
    wr_valid_i = wr; wr_idx_i = IW'(idx); wr_zs_i = zs; wr_fs_i = fs; wr_temp_i = tc;
    temp_valid_i = tv; temp_code_i = code; hyst_i = hy;
    @(negedge clk_i);
    wr_valid_i = 1'b0; temp_valid_i = 1'b0;
  endtask

  // result presented, then load checked in the following cycle and its end one cycle later
  task automatic expect_step(input string req, input bit exp_load, input int exp_band,
                             input logic [CW-1:0] exp_zs, input logic [CW-1:0] exp_fs);
    check(load_o == exp_load, req, load_o, exp_load);
    check(band_o == IW'(exp_band), req, band_o, exp_band);
    if (exp_load) begin
      check(load_band_o == IW'(exp_band), req, load_band_o, exp_band);
      check(load_zs_o == exp_zs, req, load_zs_o, exp_zs);
      check(load_fs_o == exp_fs, req, load_fs_o, exp_fs);
    end
    @(negedge clk_i);
    check(load_o == 1'b0, "R7 pulse end", load_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    check(load_o == 0 && band_valid_o == 0 && band_o == 0, "R1 in reset", {load_o, band_valid_o, band_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(load_o == 0 && band_valid_o == 0 && band_o == 0, "R1 after reset", {load_o, band_valid_o, band_o}, 0);

    // R2 fill the table in learn mode
    learn_i = 1'b1;
    for (int b = 0; b < N; b++) cycle(1, b, zs_of(b), fs_of(b), TW'((b + 1) * 1000), 0, '0, '0);
    learn_i = 1'b0;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic [35:0] e;
      e = VEC[v];
      cycle(0, 0, '0, '0, '0, 1, e[35:12], e[11:4]);
      expect_step($sformatf("R5/R9/R10 vector %0d", v), e[3], int'(e[2:0]), zs_of(int'(e[2:0])),
                  fs_of(int'(e[2:0])));
    end

    // R3 run-mode write to entry 2 in the same cycle as a result selecting it
    cycle(0, 0, '0, '0, '0, 1, 24'd100, 8'd0);
    expect_step("R2 back to band 0", 1, 0, zs_of(0), fs_of(0));
    cycle(1, 2, 24'hdead00, 24'hbeef00, 24'd3000, 1, 24'd3000, 8'd0);
    expect_step("R3 run-mode write ignored", 1, 2, zs_of(2), fs_of(2));

    // R4/R12 learn mode: result ignored, write to entry 3 accepted
    learn_i = 1'b1;
    cycle(1, 3, 24'h0abcde, 24'h0fedcb, 24'd4000, 1, 24'd6999, 8'd0);
    check(load_o == 0, "R4 no load in learn", load_o, 0);
    check(band_o == 3'd2, "R4 band held", band_o, 2);
    check(band_valid_o == 0, "R12 valid cleared", band_valid_o, 0);
    learn_i = 1'b0;
    @(negedge clk_i);

    // R6 first result after learn reloads even the same band; R2 new pair
    cycle(0, 0, '0, '0, '0, 1, 24'd3000, 8'd0);
    expect_step("R6 reload after learn", 1, 2, zs_of(2), fs_of(2));
    cycle(0, 0, '0, '0, '0, 1, 24'd3600, 8'd0);
    expect_step("R2 rewritten entry", 1, 3, 24'h0abcde, 24'h0fedcb);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule